// File: doc/BRIEF.md
# Memory Operand Address Former

This block turns an already-split operand descriptor into a memory address. A field parser upstream supplies the two-bit mode field, the three-bit operand selector, the scale/index/base fields of the optional second descriptor byte, and a displacement that it has already sign-extended to 32 bits. The block also receives the current contents of the eight general registers. From these it forms the effective address for either 16-bit or 32-bit addressing, and it picks the default segment that the access would use.

When the mode field selects a register operand instead of memory, the block raises a flag, passes the register number through, and drives the address to zero. All results are registered. They appear one clock after a cycle with `in_valid` high and then hold until the next valid input. Segment overrides, segment base addition, limit checks and register writes are handled elsewhere.

Top module: `eff_addr_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `ea`, `seg_sel`, `is_reg` and `reg_num` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. While `in_valid` is low, `ea`, `seg_sel`, `is_reg` and `reg_num` keep their values even if the other inputs change.
- R3: In 16-bit mode (`addr32`=0), selector codes 0 to 7 address BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. The only exception is mode 0 with selector 6, which is a direct address. The sum wraps modulo 2^16, and `ea[31:16]` is zero.
- R4: In 16-bit mode, the segment code is 1 (SS) for selectors 2 and 3, and for selector 6 when the mode is not 0. Every other form, including the direct address, gives code 0 (DS).
- R5: In 32-bit mode with selector not 4, selectors 0 to 7 address EAX, ECX, EDX, EBX, -, EBP, ESI, EDI. Mode 0 with selector 5 is a direct 32-bit address with DS. The EBP form gives SS, and all other forms give DS.
- R6: In 32-bit mode with selector 4, the address is base + (index << scale), where `sib_scale` gives multipliers of 1, 2, 4 and 8. An index code of 4 adds no index, whatever the scale.
- R7: For scaled forms, base code 4 (ESP) gives SS. Base code 5 gives EBP with SS when the mode is not 0. With mode 0, base code 5 means there is no base register, the displacement is added, and the segment is DS. All other base codes give DS.
- R8: The displacement is added only in modes 1 and 2 and in the no-base/direct forms. In any other mode-0 form it is ignored.
- R9: Mode 3 sets `is_reg`=1, `reg_num` to the selector, `ea` to 0 and `seg_sel` to 0. Any memory form gives `is_reg`=0 and `reg_num`=0.
- R10: 32-bit sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor valid this cycle |
| addr32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| mod_f | input | 2 | Mode field |
| rm_f | input | 3 | Operand selector field |
| sib_scale | input | 2 | Scale exponent |
| sib_index | input | 3 | Index register code |
| sib_base | input | 3 | Base register code |
| disp | input | 32 | Sign-extended displacement |
| gpr_flat | input | 256 | Register i at bits [32i+31:32i], codes EAX=0 .. EDI=7 |
| out_valid | output | 1 | Result valid |
| ea | output | 32 | Effective address |
| seg_sel | output | 2 | Default segment, 0 = DS, 1 = SS |
| is_reg | output | 1 | Operand is a register |
| reg_num | output | 3 | Register code when `is_reg` |

## Verification
The hardest cases to reach are the special encodings that reuse the same field codes with a different meaning. These are code 5 used as a base in mode 0 compared with mode 1, an index code of 4 combined with a nonzero scale, and 16-bit selector 6 in mode 0. Each one is only visible when a nonzero displacement or scale is present to make the difference show up in the address. The stimulus table places every such encoding next to a displacement or scale that would change the result if the field were misread. It also loads registers whose low halves overflow 16 bits when added, so the wrap rules are tested too.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_GPR = 8;
  localparam int SEL_W = $clog2(NUM_GPR);
  localparam int HALF_W = DATA_W / 2;

  typedef enum logic [1:0] {
    SEG_DS = 2'd0,
    SEG_SS = 2'd1
  } seg_e;

  localparam logic [1:0] MOD_REG = 2'b11;
endpackage

// File: rtl/ea16_calc.sv
module ea16_calc
  import ea_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic [1:0]    mod_f,
  input  logic [2:0]    rm_f,
  input  logic [HW-1:0] disp_lo,
  input  logic [HW-1:0] r_bx,
  input  logic [HW-1:0] r_bp,
  input  logic [HW-1:0] r_si,
  input  logic [HW-1:0] r_di,
  output logic [HW-1:0] addr,
  output seg_e          seg
);
  logic [HW-1:0] base_v, idx_v, disp_v;
  logic direct;

  always_comb begin
    direct = (mod_f == 2'b00) && (rm_f == 3'd6);
    base_v = '0;
    idx_v  = '0;
    unique case (rm_f)
      3'd0: begin base_v = r_bx; idx_v = r_si; end
      3'd1: begin base_v = r_bx; idx_v = r_di; end
      3'd2: begin base_v = r_bp; idx_v = r_si; end
      3'd3: begin base_v = r_bp; idx_v = r_di; end
      3'd4: idx_v = r_si;
      3'd5: idx_v = r_di;
      3'd6: base_v = direct ? '0 : r_bp;
      default: base_v = r_bx;
    endcase
    disp_v = (mod_f == 2'b01 || mod_f == 2'b10 || direct) ? disp_lo : '0;
    addr = base_v + idx_v + disp_v;
    if (rm_f == 3'd2 || rm_f == 3'd3 || (rm_f == 3'd6 && !direct))
      seg = SEG_SS;
    else
      seg = SEG_DS;
  end
endmodule

// File: rtl/ea32_calc.sv
module ea32_calc
  import ea_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NUM_GPR
) (
  input  logic [1:0]    mod_f,
  input  logic [2:0]    rm_f,
  input  logic [1:0]    sib_scale,
  input  logic [2:0]    sib_index,
  input  logic [2:0]    sib_base,
  input  logic [DW-1:0] disp,
  input  logic [DW-1:0] regs [NR],
  output logic [DW-1:0] addr,
  output seg_e          seg
);
  logic [DW-1:0] base_v, scaled_v, disp_v;
  logic use_disp;

  always_comb begin
    base_v   = '0;
    scaled_v = '0;
    use_disp = (mod_f != 2'b00);
    seg      = SEG_DS;
    if (rm_f == 3'd4) begin
      if (sib_index != 3'd4)
        scaled_v = regs[sib_index] << sib_scale;
      if (sib_base == 3'd5 && mod_f == 2'b00) begin
        use_disp = 1'b1;
      end else begin
        base_v = regs[sib_base];
        if (sib_base == 3'd4 || sib_base == 3'd5)
          seg = SEG_SS;
      end
    end else if (rm_f == 3'd5 && mod_f == 2'b00) begin
      use_disp = 1'b1;
    end else begin
      base_v = regs[rm_f];
      if (rm_f == 3'd5)
        seg = SEG_SS;
    end
    disp_v = use_disp ? disp : '0;
    addr   = base_v + scaled_v + disp_v;
  end
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import ea_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NUM_GPR,
  localparam int HW = DW / 2,
  localparam int SW = $clog2(NR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            addr32,
  input  logic [1:0]      mod_f,
  input  logic [2:0]      rm_f,
  input  logic [1:0]      sib_scale,
  input  logic [2:0]      sib_index,
  input  logic [2:0]      sib_base,
  input  logic [DW-1:0]   disp,
  input  logic [NR*DW-1:0] gpr_flat,
  output logic            out_valid,
  output logic [DW-1:0]   ea,
  output logic [1:0]      seg_sel,
  output logic            is_reg,
  output logic [SW-1:0]   reg_num
);
  logic [DW-1:0] regs [NR];

  for (genvar g = 0; g < NR; g++) begin : g_unpack
    assign regs[g] = gpr_flat[g*DW +: DW];
  end

  logic [HW-1:0] addr16;
  seg_e          seg16;
  logic [DW-1:0] addr32_v;
  seg_e          seg32;

  ea16_calc #(.HW(HW)) u_ea16 (
    .mod_f   (mod_f),
    .rm_f    (rm_f),
    .disp_lo (disp[HW-1:0]),
    .r_bx    (regs[3][HW-1:0]),
    .r_bp    (regs[5][HW-1:0]),
    .r_si    (regs[6][HW-1:0]),
    .r_di    (regs[7][HW-1:0]),
    .addr    (addr16),
    .seg     (seg16)
  );

  ea32_calc #(.DW(DW), .NR(NR)) u_ea32 (
    .mod_f     (mod_f),
    .rm_f      (rm_f),
    .sib_scale (sib_scale),
    .sib_index (sib_index),
    .sib_base  (sib_base),
    .disp      (disp),
    .regs      (regs),
    .addr      (addr32_v),
    .seg       (seg32)
  );

  logic          vld_d;
  logic [DW-1:0] ea_d;
  logic [1:0]    seg_d;
  logic          isr_d;
  logic [SW-1:0] rn_d;

  always_comb begin
    vld_d = in_valid;
    ea_d  = ea;
    seg_d = seg_sel;
    isr_d = is_reg;
    rn_d  = reg_num;
    if (in_valid) begin
      if (mod_f == MOD_REG) begin
        ea_d  = '0;
        seg_d = SEG_DS;
        isr_d = 1'b1;
        rn_d  = SW'(rm_f);
      end else begin
        isr_d = 1'b0;
        rn_d  = '0;
        if (addr32) begin
          ea_d  = addr32_v;
          seg_d = seg32;
        end else begin
          ea_d  = {{(DW-HW){1'b0}}, addr16};
          seg_d = seg16;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea        <= '0;
      seg_sel   <= '0;
      is_reg    <= 1'b0;
      reg_num   <= '0;
    end else begin
      out_valid <= vld_d;
      ea        <= ea_d;
      seg_sel   <= seg_d;
      is_reg    <= isr_d;
      reg_num   <= rn_d;
    end
  end
endmodule

// File: rtl/ea_chk.sv
module ea_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        addr32,
  input logic [1:0]  mod_f,
  input logic [2:0]  rm_f,
  input logic [2:0]  sib_base,
  input logic        out_valid,
  input logic [31:0] ea,
  input logic [1:0]  seg_sel,
  input logic        is_reg,
  input logic [2:0]  reg_num
);
  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(ea) && $stable(seg_sel) && $stable(is_reg) && $stable(reg_num)));
  // R9
  reg_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mod_f == 2'b11) |=>
      (is_reg && ea == 32'd0 && seg_sel == 2'd0 && reg_num == $past(rm_f)));
  // R3
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !addr32) |=> ea[31:16] == 16'd0);
  // R4
  direct16_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !addr32 && mod_f == 2'b00 && rm_f == 3'd6) |=> seg_sel == 2'd0);
  // R7
  stack_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr32 && mod_f != 2'b11 && rm_f == 3'd4 && sib_base == 3'd4)
      |=> seg_sel == 2'd1);
endmodule

bind eff_addr_unit ea_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .addr32    (addr32),
  .mod_f     (mod_f),
  .rm_f      (rm_f),
  .sib_base  (sib_base),
  .out_valid (out_valid),
  .ea        (ea),
  .seg_sel   (seg_sel),
  .is_reg    (is_reg),
  .reg_num   (reg_num)
);

// File: tb/sim_eff_addr_unit.sv
module sim_eff_addr_unit;
  localparam int CLK_PER = 10;
  localparam int NV = 22;

  typedef struct packed {
    logic        a32;
    logic [1:0]  md;
    logic [2:0]  rm;
    logic [1:0]  sc;
    logic [2:0]  ix;
    logic [2:0]  bs;
    logic [31:0] dp;
    logic [31:0] x_ea;
    logic [1:0]  x_sg;
    logic        x_ir;
    logic [2:0]  x_rn;
  } vec_t;

  // Registers: EAX=10 ECX=20 EDX=30 EBX=F000 ESP=8000 EBP=9000 ESI=1100 EDI=2200
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 3'd0, 2'd0, 3'd0, 3'd0, 32'h0000_0055, 32'h0000_0100, 2'd0, 1'b0, 3'd0}, // R3 R8 wrap
    '{1'b0, 2'd1, 3'd1, 2'd0, 3'd0, 3'd0, 32'h0000_0010, 32'h0000_1210, 2'd0, 1'b0, 3'd0}, // R3
    '{1'b0, 2'd2, 3'd2, 2'd0, 3'd0, 3'd0, 32'h0000_1234, 32'h0000_B334, 2'd1, 1'b0, 3'd0}, // R4
    '{1'b0, 2'd0, 3'd3, 2'd0, 3'd0, 3'd0, 32'h0000_0000, 32'h0000_B200, 2'd1, 1'b0, 3'd0}, // R4
    '{1'b0, 2'd1, 3'd4, 2'd0, 3'd0, 3'd0, 32'hFFFF_FFFE, 32'h0000_10FE, 2'd0, 1'b0, 3'd0}, // R3
    '{1'b0, 2'd2, 3'd5, 2'd0, 3'd0, 3'd0, 32'h0000_0100, 32'h0000_2300, 2'd0, 1'b0, 3'd0}, // R3
    '{1'b0, 2'd0, 3'd6, 2'd0, 3'd0, 3'd0, 32'h0000_ABCD, 32'h0000_ABCD, 2'd0, 1'b0, 3'd0}, // R4 direct
    '{1'b0, 2'd1, 3'd6, 2'd0, 3'd0, 3'd0, 32'h0000_0004, 32'h0000_9004, 2'd1, 1'b0, 3'd0}, // R4
    '{1'b0, 2'd0, 3'd7, 2'd0, 3'd0, 3'd0, 32'h0000_0077, 32'h0000_F000, 2'd0, 1'b0, 3'd0}, // R8
    '{1'b0, 2'd3, 3'd5, 2'd0, 3'd0, 3'd0, 32'h0000_1111, 32'h0000_0000, 2'd0, 1'b1, 3'd5}, // R9
    '{1'b1, 2'd0, 3'd0, 2'd0, 3'd0, 3'd0, 32'h0000_0099, 32'h0000_0010, 2'd0, 1'b0, 3'd0}, // R5 R8
    '{1'b1, 2'd1, 3'd3, 2'd0, 3'd0, 3'd0, 32'hFFFF_FFF0, 32'h0000_EFF0, 2'd0, 1'b0, 3'd0}, // R5
    '{1'b1, 2'd0, 3'd5, 2'd0, 3'd0, 3'd0, 32'h1234_5678, 32'h1234_5678, 2'd0, 1'b0, 3'd0}, // R5 direct
    '{1'b1, 2'd2, 3'd5, 2'd0, 3'd0, 3'd0, 32'h0000_0100, 32'h0000_9100, 2'd1, 1'b0, 3'd0}, // R5
    '{1'b1, 2'd0, 3'd4, 2'd2, 3'd1, 3'd0, 32'h0000_0500, 32'h0000_0090, 2'd0, 1'b0, 3'd0}, // R6 R8
    '{1'b1, 2'd0, 3'd4, 2'd3, 3'd6, 3'd4, 32'h0000_0000, 32'h0001_0800, 2'd1, 1'b0, 3'd0}, // R6 R7
    '{1'b1, 2'd1, 3'd4, 2'd3, 3'd4, 3'd3, 32'h0000_0008, 32'h0000_F008, 2'd0, 1'b0, 3'd0}, // R6 no index
    '{1'b1, 2'd0, 3'd4, 2'd1, 3'd2, 3'd5, 32'h0040_0000, 32'h0040_0060, 2'd0, 1'b0, 3'd0}, // R7 no base
    '{1'b1, 2'd1, 3'd4, 2'd0, 3'd0, 3'd5, 32'h0000_0010, 32'h0000_9020, 2'd1, 1'b0, 3'd0}, // R7 EBP
    '{1'b1, 2'd2, 3'd4, 2'd0, 3'd3, 3'd7, 32'hFFFF_F000, 32'h0001_0200, 2'd0, 1'b0, 3'd0}, // R10
    '{1'b1, 2'd3, 3'd2, 2'd0, 3'd0, 3'd0, 32'h0000_0000, 32'h0000_0000, 2'd0, 1'b1, 3'd2}, // R9
    '{1'b1, 2'd0, 3'd6, 2'd0, 3'd0, 3'd0, 32'h0000_DEAD, 32'h0000_1100, 2'd0, 1'b0, 3'd0}  // R8
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        addr32;
  logic [1:0]  mod_f;
  logic [2:0]  rm_f;
  logic [1:0]  sib_scale;
  logic [2:0]  sib_index;
  logic [2:0]  sib_base;
  logic [31:0] disp;
  logic [255:0] gpr_flat;
  logic        out_valid;
  logic [31:0] ea;
  logic [1:0]  seg_sel;
  logic        is_reg;
  logic [2:0]  reg_num;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  eff_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr32(addr32),
    .mod_f(mod_f), .rm_f(rm_f), .sib_scale(sib_scale), .sib_index(sib_index),
    .sib_base(sib_base), .disp(disp), .gpr_flat(gpr_flat),
    .out_valid(out_valid), .ea(ea), .seg_sel(seg_sel), .is_reg(is_reg),
    .reg_num(reg_num)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    addr32 = v.a32; mod_f = v.md; rm_f = v.rm; sib_scale = v.sc;
    sib_index = v.ix; sib_base = v.bs; disp = v.dp;
  endtask

  task automatic check_vec(input string req, input vec_t v);
    chk({req, " ea"},  ea, v.x_ea);
    chk({req, " seg"}, {30'd0, seg_sel}, {30'd0, v.x_sg});
    chk({req, " is_reg"}, {31'd0, is_reg}, {31'd0, v.x_ir});
    chk({req, " reg_num"}, {29'd0, reg_num}, {29'd0, v.x_rn});
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cyc);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    drive(VECS[0]);
    gpr_flat = {32'h0000_2200, 32'h0000_1100, 32'h0000_9000, 32'h0000_8000,
                32'h0000_F000, 32'h0000_0030, 32'h0000_0020, 32'h0000_0010};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 ea", ea, 32'd0);
    chk("R1 is_reg", {31'd0, is_reg}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 out_valid after in_valid", {31'd0, out_valid}, 32'd1);
      check_vec($sformatf("vec %0d R3 R4 R5 R6 R7 R8 R9 R10", i), VECS[i]);
      @(negedge clk);
      chk("R2 out_valid low", {31'd0, out_valid}, 32'd0);
    end

    // R2 hold: change inputs with in_valid low; results keep last vector
    drive(VECS[2]);
    repeat (3) @(negedge clk);
    check_vec("R2 hold", VECS[NV-1]);

    // R2 back-to-back valid inputs
    drive(VECS[14]);
    in_valid = 1'b1;
    @(negedge clk);
    check_vec("R2 b2b first", VECS[14]);
    drive(VECS[9]);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 b2b valid", {31'd0, out_valid}, 32'd1);
    check_vec("R2 b2b second R9", VECS[9]);

    // R1 reset mid-run clears a register-operand result
    rst_n = 1'b0;
    #1;
    chk("R1 async is_reg", {31'd0, is_reg}, 32'd0);
    chk("R1 async reg_num", {29'd0, reg_num}, 32'd0);
    chk("R1 async seg", {30'd0, seg_sel}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
  end
endmodule